// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller Pair

This block joins two eight-input interrupt controller cores into one sixteen-line unit. The primary core takes request lines 0 to 7. The secondary core takes lines 8 to 15. The secondary core's request output is wired into input 2 of the primary core, so line 2 of the external request bus is not used. The processor sees one interrupt output. It acknowledges with a stream of single-cycle pulses, taken in pairs. The first pulse of a pair commits a grant. The vector comes back one cycle after the second pulse.

When the primary core grants an input that its cascade word marks as linked, it places that input number on a 3-bit cascade bus. The secondary core answers only when that number equals its programmed identity. For any other grant the primary core supplies the vector itself. Each core keeps its own in-service state. A request served by the secondary core therefore needs an end-of-interrupt command at each core.

The cores are programmed through four byte-wide I/O ports. An address decoder routes single-cycle write and read strobes to a command port and a data port on each core. The primary core sits at 020h/021h and the secondary core at 0A0h/0A1h.

Top module: `pic_pair`

## Requirements
- R1: After reset, int_o and vec_vld_o are 0 and a read of either data port (021h, 0A1h) returns FFh, meaning every request is masked.
- R2: Only addresses 020h, 021h, 0A0h and 0A1h reach a core. A write to any other address changes nothing, and rdata_o is 00h when rd_i is low or the address misses.
- R3: A command-port write with bit 4 set starts initialization. It clears the mask, pending and in-service bits of that core. The next data-port writes are taken in order: the vector base (bits 7:3), then the cascade word if bit 1 of the start byte was 0, then a mode byte that is ignored if bit 0 was 1. Data-port writes after that set the mask.
- R4: A rising edge on a request line sets its pending bit, which stays set until it is granted. A masked pending bit keeps int_o low, but it is still visible in a pending-register read. A command write with bits 4:3 = 01 and bit 1 set selects the read source: bit 0 = 0 gives the pending register and bit 0 = 1 gives the in-service register.
- R5: A lower input number has higher priority. While an in-service bit is set, requests of the same or lower priority at that core cannot raise int_o. The secondary lines rank in the slot of primary input 2.
- R6: int_o is high while an unmasked pending request beats the in-service state. On the first pulse of a pair, the winner moves from pending to in-service. One cycle after the second pulse, vec_vld_o is high for one cycle with vec_o = {base[7:3], level}.
- R7: A rising edge on the secondary interrupt output sets primary pending bit 2 one cycle later. A grant on a linked primary input puts that input number on cas_o, and the secondary core whose identity matches supplies the vector.
- R8: A grant on an unlinked primary input makes the primary core supply the vector, and the secondary in-service register stays unchanged. At most one core ever supplies a vector.
- R9: A pair of pulses with nothing eligible returns vector {base, 7} and sets no in-service bit.
- R10: A command write with bits 7:5 = 001 clears the highest-priority in-service bit. Bits 7:5 = 011 clear the bit numbered by bits 2:0. A secondary request needs one such command at each core, and one alone leaves the other core's bit set.
- R11: When the cascade number does not match the secondary identity, no vector is returned, while the primary still marks input 2 in service.
- R12: External request line 2 has no effect on int_o or on the primary pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Request lines, edge sensitive; bit 2 unused |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 8 | I/O port address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 00h when not selected |
| inta_i | input | 1 | Acknowledge pulse, one cycle per pulse |
| int_o | output | 1 | Interrupt request to the processor |
| cas_o | output | 3 | Cascade number during a linked first pulse |
| vec_o | output | 8 | Vector byte |
| vec_vld_o | output | 1 | Vector valid, one cycle |

## Verification
The bench builds the pair with its default parameters: ports at 020h/0A0h and the link on primary input 2. With these values the whole sixteen-line space is small enough to sweep fully. Every usable line is served alone, with both end-of-interrupt forms, and all 105 pairs of usable lines are raised together. The expected winner comes from an arithmetic priority key in which the secondary lines fill the slot of primary input 2. Directed runs add mask readback, nesting, a spurious acknowledge, a reduced start sequence and a mismatched identity.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned LVL_W = $clog2(LINES);

  // command byte fields
  localparam int unsigned B_INIT  = 4;
  localparam int unsigned B_OCW3  = 3;
  localparam int unsigned B_EOI   = 5;
  localparam int unsigned B_SPEC  = 6;
  localparam int unsigned B_ROT   = 7;
  localparam int unsigned B_SNGL  = 1;
  localparam int unsigned B_MODE  = 0;
  localparam int unsigned B_RDEN  = 1;
  localparam int unsigned B_RDISR = 0;

  typedef enum logic [1:0] {
    CFG_IDLE = 2'd0,
    CFG_BASE = 2'd1,
    CFG_CASC = 2'd2,
    CFG_MODE = 2'd3
  } cfg_state_e;

  typedef struct packed {
    logic cmd;
    logic dat;
  } core_wr_t;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  // lowest set index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_port_decode.sv
module pic_port_decode
  import pic_pkg::*;
#(
  parameter logic [7:0] MASTER_BASE = 8'h20,
  parameter logic [7:0] SLAVE_BASE  = 8'hA0
) (
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] m_cmd_rd_i,
  input  logic [7:0] m_dat_rd_i,
  input  logic [7:0] s_cmd_rd_i,
  input  logic [7:0] s_dat_rd_i,
  output core_wr_t   m_wr_o,
  output core_wr_t   s_wr_o,
  output logic [7:0] rdata_o
);
  logic m_hit, s_hit, odd;

  assign m_hit = (addr_i[7:1] == MASTER_BASE[7:1]);
  assign s_hit = (addr_i[7:1] == SLAVE_BASE[7:1]);
  assign odd   = addr_i[0];

  assign m_wr_o.cmd = wr_i & m_hit & ~odd;
  assign m_wr_o.dat = wr_i & m_hit &  odd;
  assign s_wr_o.cmd = wr_i & s_hit & ~odd;
  assign s_wr_o.dat = wr_i & s_hit &  odd;

  always_comb begin
    rdata_o = 8'h00;
    if (rd_i) begin
      if (m_hit)      rdata_o = odd ? m_dat_rd_i : m_cmd_rd_i;
      else if (s_hit) rdata_o = odd ? s_dat_rd_i : s_cmd_rd_i;
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  core_wr_t         wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             inta_i,
  input  logic [LVL_W-1:0] cas_i,
  input  logic             cas_en_i,
  output logic [LVL_W-1:0] cas_o,
  output logic             cas_en_o,
  output logic             int_o,
  output logic [7:0]       cmd_rd_o,
  output logic [7:0]       dat_rd_o,
  output logic [LINES-1:0] irr_o,
  output logic [LINES-1:0] isr_o,
  output logic [7:0]       vec_o,
  output logic             vec_vld_o
);
  // state
  logic [LINES-1:0] req_q, irr_q, isr_q, imr_q;
  logic [LINES-1:0] irr_n, isr_n, imr_n;
  logic [7:LVL_W]   base_q, base_n;
  logic [7:0]       link_q, link_n;
  cfg_state_e       cfg_q, cfg_n;
  logic             sngl_q, sngl_n, mode_q, mode_n;
  logic             rd_isr_q, rd_isr_n;
  logic             phase_q, phase_n;
  logic             sel_q, sel_n;
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic [7:0]       vec_q, vec_n;
  logic             vld_q, vld_n;
  logic             cfg_en;

  // resolution
  logic [LINES-1:0] rise, pend, allow, elig, clr;
  logic             isr_any, elig_any;
  logic [LVL_W-1:0] isr_top, elig_lvl;
  logic             ack1, ack2, respond, via_link, id_match, drive;

  assign rise = req_i & ~req_q;
  assign pend = irr_q & ~imr_q;

  pic_prio #(.N(LINES)) u_isr_prio (.vec_i(isr_q), .any_o(isr_any), .idx_o(isr_top));

  assign allow = isr_any ? ((LINES'(1) << isr_top) - LINES'(1)) : '1;
  assign elig  = pend & allow;

  pic_prio #(.N(LINES)) u_req_prio (.vec_i(elig), .any_o(elig_any), .idx_o(elig_lvl));

  assign ack1 = inta_i & ~phase_q;
  assign ack2 = inta_i &  phase_q;

  // role: the primary always answers the first pulse; the secondary only on an identity match
  assign id_match = cas_en_i & (cas_i == link_q[LVL_W-1:0]);
  assign via_link = IS_MASTER & elig_any & link_q[elig_lvl];
  assign respond  = IS_MASTER ? ack1 : (ack1 & id_match);
  assign drive    = ~via_link;

  assign cas_o    = via_link ? elig_lvl : '0;
  assign cas_en_o = ack1 & via_link;

  assign clr = (respond & elig_any) ? (LINES'(1) << elig_lvl) : '0;

  // next state
  always_comb begin
    irr_n    = (irr_q & ~clr) | rise;
    isr_n    = isr_q | clr;
    imr_n    = imr_q;
    base_n   = base_q;
    link_n   = link_q;
    cfg_n    = cfg_q;
    sngl_n   = sngl_q;
    mode_n   = mode_q;
    rd_isr_n = rd_isr_q;
    phase_n  = inta_i ? ~phase_q : phase_q;
    sel_n    = sel_q;
    lvl_n    = lvl_q;
    vec_n    = vec_q;
    vld_n    = 1'b0;

    if (ack1) begin
      sel_n = respond & drive;
      lvl_n = elig_any ? elig_lvl : LVL_W'(LINES - 1);
    end
    if (ack2) begin
      sel_n = 1'b0;
      if (sel_q) begin
        vld_n = 1'b1;
        vec_n = {base_q, lvl_q};
      end
    end

    if (wr_i.cmd) begin
      if (wdata_i[B_INIT]) begin
        cfg_n    = CFG_BASE;
        sngl_n   = wdata_i[B_SNGL];
        mode_n   = wdata_i[B_MODE];
        imr_n    = '0;
        isr_n    = '0;
        irr_n    = '0;
        rd_isr_n = 1'b0;
        phase_n  = 1'b0;
        sel_n    = 1'b0;
      end else if (wdata_i[B_OCW3]) begin
        if (wdata_i[B_RDEN]) rd_isr_n = wdata_i[B_RDISR];
      end else if (wdata_i[B_EOI] && !wdata_i[B_ROT]) begin
        if (wdata_i[B_SPEC])  isr_n[wdata_i[LVL_W-1:0]] = 1'b0;
        else if (isr_any)     isr_n[isr_top] = 1'b0;
      end
    end else if (wr_i.dat) begin
      unique case (cfg_q)
        CFG_IDLE: imr_n = wdata_i;
        CFG_BASE: begin
          base_n = wdata_i[7:LVL_W];
          cfg_n  = !sngl_q ? CFG_CASC : (mode_q ? CFG_MODE : CFG_IDLE);
        end
        CFG_CASC: begin
          link_n = wdata_i;
          cfg_n  = mode_q ? CFG_MODE : CFG_IDLE;
        end
        CFG_MODE: cfg_n = CFG_IDLE;
        default:  cfg_n = CFG_IDLE;
      endcase
    end
  end

  assign cfg_en = wr_i.cmd | wr_i.dat;

  // registers: request tracking and acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      irr_q   <= '0;
      isr_q   <= '0;
      phase_q <= 1'b0;
      sel_q   <= 1'b0;
      lvl_q   <= '0;
      vec_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      req_q   <= req_i;
      irr_q   <= irr_n;
      isr_q   <= isr_n;
      phase_q <= phase_n;
      sel_q   <= sel_n;
      lvl_q   <= lvl_n;
      vec_q   <= vec_n;
      vld_q   <= vld_n;
    end
  end

  // registers: programming state, enabled by bus writes only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q    <= '1;
      base_q   <= '0;
      link_q   <= '0;
      cfg_q    <= CFG_IDLE;
      sngl_q   <= 1'b0;
      mode_q   <= 1'b0;
      rd_isr_q <= 1'b0;
    end else if (cfg_en) begin
      imr_q    <= imr_n;
      base_q   <= base_n;
      link_q   <= link_n;
      cfg_q    <= cfg_n;
      sngl_q   <= sngl_n;
      mode_q   <= mode_n;
      rd_isr_q <= rd_isr_n;
    end
  end

  assign int_o     = (cfg_q == CFG_IDLE) & elig_any;
  assign cmd_rd_o  = rd_isr_q ? isr_q : irr_q;
  assign dat_rd_o  = imr_q;
  assign irr_o     = irr_q;
  assign isr_o     = isr_q;
  assign vec_o     = vec_q;
  assign vec_vld_o = vld_q;
endmodule

// File: rtl/pic_pair.sv
module pic_pair
  import pic_pkg::*;
#(
  parameter logic [7:0]  MASTER_BASE = 8'h20,
  parameter logic [7:0]  SLAVE_BASE  = 8'hA0,
  parameter int unsigned LINK_INPUT  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        inta_i,
  output logic        int_o,
  output logic [2:0]  cas_o,
  output logic [7:0]  vec_o,
  output logic        vec_vld_o
);
  localparam logic [LINES-1:0] LINK_MASK = LINES'(1) << LINK_INPUT;

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  core_wr_t         m_wr, s_wr;
  logic [7:0]       m_cmd_rd, m_dat_rd, s_cmd_rd, s_dat_rd;
  logic [LINES-1:0] m_req, m_irr, m_isr, s_irr, s_isr;
  logic             s_int, m_int;
  logic [LVL_W-1:0] m_cas, s_cas_unused;
  logic             m_cas_en, s_cas_en_unused;
  logic [7:0]       m_vec, s_vec;
  logic             m_vld, s_vld;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  pic_port_decode #(.MASTER_BASE(MASTER_BASE), .SLAVE_BASE(SLAVE_BASE)) u_decode (
    .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .m_cmd_rd_i(m_cmd_rd), .m_dat_rd_i(m_dat_rd),
    .s_cmd_rd_i(s_cmd_rd), .s_dat_rd_i(s_dat_rd),
    .m_wr_o(m_wr), .s_wr_o(s_wr), .rdata_o(rdata_o)
  );

  assign m_req = (irq_i[7:0] & ~LINK_MASK) | ({LINES{s_int}} & LINK_MASK);

  pic_core #(.IS_MASTER(1'b1)) u_master (
    .clk(clk), .rst_n(rst_sync_n), .req_i(m_req), .wr_i(m_wr), .wdata_i(wdata_i),
    .inta_i(inta_i), .cas_i('0), .cas_en_i(1'b0),
    .cas_o(m_cas), .cas_en_o(m_cas_en), .int_o(m_int),
    .cmd_rd_o(m_cmd_rd), .dat_rd_o(m_dat_rd), .irr_o(m_irr), .isr_o(m_isr),
    .vec_o(m_vec), .vec_vld_o(m_vld)
  );

  pic_core #(.IS_MASTER(1'b0)) u_slave (
    .clk(clk), .rst_n(rst_sync_n), .req_i(irq_i[15:8]), .wr_i(s_wr), .wdata_i(wdata_i),
    .inta_i(inta_i), .cas_i(m_cas), .cas_en_i(m_cas_en),
    .cas_o(s_cas_unused), .cas_en_o(s_cas_en_unused), .int_o(s_int),
    .cmd_rd_o(s_cmd_rd), .dat_rd_o(s_dat_rd), .irr_o(s_irr), .isr_o(s_isr),
    .vec_o(s_vec), .vec_vld_o(s_vld)
  );

  assign int_o     = m_int;
  assign cas_o     = m_cas_en ? m_cas : 3'd0;
  assign vec_vld_o = m_vld | s_vld;
  assign vec_o     = m_vld ? m_vec : (s_vld ? s_vec : 8'h00);
endmodule

// File: rtl/pic_pair_chk.sv
module pic_pair_chk #(
  parameter logic [7:0]  MASTER_BASE = 8'h20,
  parameter int unsigned LINK_INPUT  = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       inta_i,
  input logic       wr_i,
  input logic [7:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       vec_vld_o,
  input logic       s_int,
  input logic       m_vld,
  input logic       s_vld,
  input logic [7:0] m_irr,
  input logic [7:0] m_isr
);
  logic m_cmd_wr;
  assign m_cmd_wr = wr_i && (addr_i == MASTER_BASE);

  // R8: never both cores on the vector path
  a_r8_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_vld, s_vld}));

  // R6: a vector only follows an acknowledge pulse
  a_r6_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld_o |-> $past(inta_i));

  // R7: a secondary request edge reaches the linked primary input
  a_r7_slave_edge_to_master: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(s_int) && !(m_cmd_wr && wdata_i[4])) |=> m_irr[LINK_INPUT]);

  // R10: a specific end-of-interrupt clears the named bit
  a_r10_specific_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cmd_wr && (wdata_i[7:3] == 5'b01100) && !inta_i) |=> !m_isr[$past(wdata_i[2:0])]);
endmodule

bind pic_pair pic_pair_chk #(.MASTER_BASE(MASTER_BASE), .LINK_INPUT(LINK_INPUT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .inta_i(inta_i), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .vec_vld_o(vec_vld_o), .s_int(s_int), .m_vld(m_vld),
  .s_vld(s_vld), .m_irr(m_irr), .m_isr(m_isr)
);

// File: tb/pic_pair_tb_top.sv
module pic_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq;
  logic        wr, rd, inta;
  logic [7:0]  addr, wdata;
  logic [7:0]  rdata, vec;
  logic        int_o, vec_vld;
  logic [2:0]  cas;
  int          n_checks = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  pic_pair dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .inta_i(inta), .int_o(int_o), .cas_o(cas),
    .vec_o(vec), .vec_vld_o(vec_vld)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic do_ack(output logic v, output logic [7:0] o);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    v = vec_vld; o = vec;
  endtask

  function automatic logic [7:0] vec_of(input int l);
    return (l < 8) ? 8'(8'h08 + l) : 8'(8'h70 + (l - 8));
  endfunction

  function automatic logic [7:0] m_isr_of(input int l);
    return (l < 8) ? 8'(1 << l) : 8'h04;
  endfunction

  function automatic logic [7:0] s_isr_of(input int l);
    return (l < 8) ? 8'h00 : 8'(1 << (l - 8));
  endfunction

  function automatic int key_of(input int l);
    return (l < 8) ? l * 16 : 32 + (l - 8);
  endfunction

  task automatic eoi_line(input int l, input bit spec);
    if (l >= 8) bus_wr(8'hA0, spec ? 8'(8'h60 | (l - 8)) : 8'h20);
    bus_wr(8'h20, spec ? 8'(8'h60 | ((l < 8) ? l : 2)) : 8'h20);
  endtask

  task automatic init_slave(input logic [7:0] id);
    bus_wr(8'hA0, 8'h11); bus_wr(8'hA1, 8'h70); bus_wr(8'hA1, id); bus_wr(8'hA1, 8'h01);
    bus_wr(8'hA0, 8'h0B);
  endtask

  initial begin
    logic [7:0] d;
    logic       v;
    logic [7:0] o;
    int         w, lo;
    rst_n = 1'b0; irq = '0; wr = 1'b0; rd = 1'b0; inta = 1'b0; addr = '0; wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 int_o", {7'd0, int_o}, 8'h00);
    chk("R1 vec_vld", {7'd0, vec_vld}, 8'h00);
    bus_rd(8'h21, d); chk("R1 primary mask", d, 8'hFF);
    bus_rd(8'hA1, d); chk("R1 secondary mask", d, 8'hFF);

    // R3 full start sequence on both cores
    bus_wr(8'h20, 8'h11); bus_wr(8'h21, 8'h08); bus_wr(8'h21, 8'h04); bus_wr(8'h21, 8'h01);
    bus_wr(8'h20, 8'h0B);
    init_slave(8'h02);
    bus_rd(8'h21, d); chk("R3 mask cleared by init", d, 8'h00);

    // R2 decode
    bus_wr(8'h23, 8'hFF); bus_wr(8'hA3, 8'hFF);
    bus_rd(8'h21, d); chk("R2 stray write primary", d, 8'h00);
    bus_rd(8'hA1, d); chk("R2 stray write secondary", d, 8'h00);
    bus_rd(8'h30, d); chk("R2 miss read", d, 8'h00);
    @(negedge clk); addr = 8'h21; #1 chk("R2 no read strobe", rdata, 8'h00);

    // R9 spurious acknowledge
    do_ack(v, o);
    chk("R9 vld", {7'd0, v}, 8'h01);
    chk("R9 vector", o, 8'h0F);
    bus_rd(8'h20, d); chk("R9 no isr", d, 8'h00);

    // single-line sweep: R6 R7 R8 R10
    for (int l = 0; l < 16; l++) begin
      if (l == 2) continue;
      @(negedge clk); irq[l] = 1'b1;
      idle(3);
      chk($sformatf("R6 int line %0d", l), {7'd0, int_o}, 8'h01);
      do_ack(v, o);
      chk($sformatf("R6 vld line %0d", l), {7'd0, v}, 8'h01);
      chk($sformatf("%s vector line %0d", (l >= 8) ? "R7" : "R8", l), o, vec_of(l));
      bus_rd(8'h20, d); chk($sformatf("R6 primary isr line %0d", l), d, m_isr_of(l));
      bus_rd(8'hA0, d); chk($sformatf("R8 secondary isr line %0d", l), d, s_isr_of(l));
      irq[l] = 1'b0;
      if (l >= 8) begin
        bus_wr(8'hA0, l[0] ? 8'(8'h60 | (l - 8)) : 8'h20);
        bus_rd(8'h20, d); chk($sformatf("R10 primary kept line %0d", l), d, 8'h04);
        bus_rd(8'hA0, d); chk($sformatf("R10 secondary cleared line %0d", l), d, 8'h00);
      end
      bus_wr(8'h20, l[0] ? 8'(8'h60 | ((l < 8) ? l : 2)) : 8'h20);
      bus_rd(8'h20, d); chk($sformatf("R10 primary cleared line %0d", l), d, 8'h00);
      idle(2);
      chk($sformatf("R6 int idle line %0d", l), {7'd0, int_o}, 8'h00);
    end

    // R5 nesting
    @(negedge clk); irq[5] = 1'b1; idle(3);
    do_ack(v, o); chk("R5 first vector", o, 8'h0D);
    @(negedge clk); irq[6] = 1'b1; idle(3);
    chk("R5 lower blocked", {7'd0, int_o}, 8'h00);
    @(negedge clk); irq[3] = 1'b1; idle(3);
    chk("R5 higher passes", {7'd0, int_o}, 8'h01);
    do_ack(v, o); chk("R5 nested vector", o, 8'h0B);
    bus_wr(8'h20, 8'h20);
    bus_rd(8'h20, d); chk("R10 nonspecific clears top", d, 8'h20);
    idle(1); chk("R5 still blocked", {7'd0, int_o}, 8'h00);
    bus_wr(8'h20, 8'h20); idle(1);
    chk("R5 released", {7'd0, int_o}, 8'h01);
    do_ack(v, o); chk("R5 deferred vector", o, 8'h0E);
    bus_wr(8'h20, 8'h20);
    irq = '0; idle(3);

    // R4 masking and R12 unused line
    bus_wr(8'h20, 8'h0A); bus_wr(8'h21, 8'h02);
    @(negedge clk); irq[1] = 1'b1; irq[2] = 1'b1; idle(3);
    chk("R4 masked int", {7'd0, int_o}, 8'h00);
    bus_rd(8'h20, d); chk("R4 R12 pending read", d, 8'h02);
    bus_wr(8'h21, 8'h00); idle(1);
    chk("R4 unmasked int", {7'd0, int_o}, 8'h01);
    do_ack(v, o); chk("R4 vector", o, 8'h09);
    bus_wr(8'h20, 8'h0B); bus_wr(8'h20, 8'h20);
    idle(2); chk("R12 line 2 silent", {7'd0, int_o}, 8'h00);
    irq = '0; idle(3);

    // R11 identity mismatch, with reduced start sequence (R3)
    bus_wr(8'hA0, 8'h10); bus_wr(8'hA1, 8'h70); bus_wr(8'hA1, 8'h03); bus_wr(8'hA1, 8'h5A);
    bus_rd(8'hA1, d); chk("R3 short sequence mask", d, 8'h5A);
    bus_wr(8'hA1, 8'h00); bus_wr(8'hA0, 8'h0B);
    @(negedge clk); irq[8] = 1'b1; idle(3);
    chk("R11 int", {7'd0, int_o}, 8'h01);
    do_ack(v, o); chk("R11 no vector", {7'd0, v}, 8'h00);
    bus_rd(8'h20, d); chk("R11 primary isr", d, 8'h04);
    bus_rd(8'hA0, d); chk("R11 secondary isr", d, 8'h00);
    bus_wr(8'h20, 8'h20);
    irq = '0;
    init_slave(8'h02);
    idle(3); chk("R11 restored idle", {7'd0, int_o}, 8'h00);

    // R5 exhaustive pair sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        if (a == 2 || b == 2) continue;
        @(negedge clk); irq[a] = 1'b1; irq[b] = 1'b1;
        idle(3);
        w  = (key_of(a) < key_of(b)) ? a : b;
        lo = (w == a) ? b : a;
        do_ack(v, o); chk($sformatf("R5 pair %0d/%0d winner", a, b), o, vec_of(w));
        eoi_line(w, 1'b0); idle(3);
        chk($sformatf("R5 pair %0d/%0d second int", a, b), {7'd0, int_o}, 8'h01);
        do_ack(v, o); chk($sformatf("R5 pair %0d/%0d loser", a, b), o, vec_of(lo));
        eoi_line(lo, 1'b0);
        irq[a] = 1'b0; irq[b] = 1'b0;
        idle(3);
        chk($sformatf("R5 pair %0d/%0d idle", a, b), {7'd0, int_o}, 8'h00);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule